// File: doc/BRIEF.md
# Host Command Packet Handler

This block sits between the parallel byte FIFO of a USB bridge device and a 128-entry register bank inside the FPGA. A host PC sends command packets through the bridge. Each packet begins with a one-byte opcode. A write packet then carries a 16-bit word as two bytes, and the block stores that word in the addressed register. A read packet has no payload. For a read, the block fetches the addressed register and returns its value to the bridge as two bytes.

When there is no host command waiting and the acquisition sample FIFO holds data, the block takes one sample word and sends it to the host. It then checks again for a command before it takes the next sample.

The register bank is split into regions. Addresses 0 to 27 are general registers. Addresses 28 to 52 and 78 to 102 are the host-readable areas of channel 1 and channel 2, and the user logic fills them. Addresses 53 to 77 and 103 to 127 are the host-writable areas of channel 1 and channel 2, and the user logic consumes them.

The control FSM has these states: IDLE, TAKE_CMD, PARSE, GET_LO, GET_HI, WR_REG, RD_REG, ACQ_POP, SEND_LO and SEND_HI. Its transitions are:

- IDLE goes to TAKE_CMD when a command byte is waiting. Otherwise it goes to ACQ_POP when a sample is waiting.
- TAKE_CMD pops the opcode and goes to PARSE.
- PARSE goes to RD_REG for a read and to GET_LO for a write.
- GET_LO and GET_HI each pop one data byte, then the FSM goes to WR_REG.
- WR_REG goes to IDLE.
- RD_REG and ACQ_POP load the outgoing word, then the FSM goes to SEND_LO.
- SEND_LO goes to SEND_HI once a byte has been written to the bridge.
- SEND_HI goes to IDLE once a byte has been written to the bridge.

Top module: `usb_cmd_handler`

## Requirements
- R1: After reset, every register reads 0, and rx_rd, tx_wr and acq_rd are low.
- R2: Opcode bit 7 = 0 marks a write to the register at address bits 6:0. The next two bytes give the data, low byte first, and the register takes that value. Register 0 is the exception: only its bits 15:1 take the data.
- R3: Opcode bit 7 = 1 marks a read of the register at address bits 6:0. The block writes the value to the bridge as two bytes, low byte first.
- R4: A host write to a host-readable channel address (28–52 or 78–102) is dropped. Its two data bytes are still consumed, and bit 0 of register 0 is set. That bit stays set until reset, including through host writes to register 0.
- R5: tx_wr is only asserted while tx_full is low. A reply waits as long as tx_full is high and is then sent complete.
- R6: With no command waiting, each word in the acquisition FIFO is sent to the bridge as two bytes, low byte first, in FIFO order.
- R7: A waiting host command is served before a waiting acquisition word. Each acquisition word is taken with a single one-cycle acq_rd pulse.
- R8: The user write port changes only the host-readable channel addresses (28–52, 78–102). The user read port returns any register combinationally.
- R9: rx_rd is only asserted while rx_not_empty is high, and acq_rd only while acq_not_empty is high. Every byte of a packet and every queued sample is consumed exactly once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_not_empty | input | 1 | Bridge holds a received byte |
| rx_data | input | 8 | Head byte from bridge (first-word fall-through) |
| rx_rd | output | 1 | Pop the head byte from the bridge |
| tx_full | input | 1 | Bridge transmit FIFO cannot accept a byte |
| tx_data | output | 8 | Byte toward the host |
| tx_wr | output | 1 | Write tx_data into the bridge |
| acq_not_empty | input | 1 | Acquisition FIFO holds a sample |
| acq_data | input | 16 | Head sample (first-word fall-through) |
| acq_rd | output | 1 | Pop the head sample |
| usr_wr_en | input | 1 | User write strobe |
| usr_addr | input | 7 | User write address |
| usr_wdata | input | 16 | User write data |
| usr_raddr | input | 7 | User read address |
| usr_rdata | output | 16 | Register contents at usr_raddr |

## Verification
The checks are timed from the clock edge at which bytes become visible on the bridge side. A write packet updates its register on the sixth edge. A read reply puts its two bytes on edges five and six. A streamed sample puts its bytes on edges three and four, and the next sample follows four edges later. Each scenario task waits a fixed margin of 12 to 30 cycles after its stimulus, well past these edges, and then samples on the falling edge. Stall and priority checks compare the captured byte order and byte count, not the arrival times, so they depend only on ordering.

// File: rtl/usbcmd_pkg.sv
package usbcmd_pkg;
    localparam int unsigned ADDR_W  = 7;
    localparam int unsigned DATA_W  = 16;
    localparam int unsigned BYTE_W  = 8;
    localparam int unsigned DEPTH   = 1 << ADDR_W;

    // host-readable channel regions (filled by user logic)
    localparam int unsigned CH1_IN_LO = 28;
    localparam int unsigned CH1_IN_HI = 52;
    localparam int unsigned CH2_IN_LO = 78;
    localparam int unsigned CH2_IN_HI = 102;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_TAKE_CMD,
        ST_PARSE,
        ST_GET_LO,
        ST_GET_HI,
        ST_WR_REG,
        ST_RD_REG,
        ST_ACQ_POP,
        ST_SEND_LO,
        ST_SEND_HI
    } cmd_state_e;

    function automatic logic host_ro(input logic [ADDR_W-1:0] a);
        int unsigned v;
        v = int'(a);
        return ((v >= CH1_IN_LO) && (v <= CH1_IN_HI)) ||
               ((v >= CH2_IN_LO) && (v <= CH2_IN_HI));
    endfunction
endpackage

// File: rtl/usbcmd_reg_bank.sv
module usbcmd_reg_bank
    import usbcmd_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hw_en,
    input  logic [ADDR_W-1:0] hw_addr,
    input  logic [DATA_W-1:0] hw_data,
    input  logic              err_set,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data,
    input  logic              usr_wr_en,
    input  logic [ADDR_W-1:0] usr_addr,
    input  logic [DATA_W-1:0] usr_wdata,
    input  logic [ADDR_W-1:0] usr_raddr,
    output logic [DATA_W-1:0] usr_rdata,
    output logic              err_flag
);
    logic [DATA_W-1:0] regs [DEPTH];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) regs[i] <= '0;
        end else begin
            if (hw_en) begin
                if (hw_addr == '0)
                    regs[0][DATA_W-1:1] <= hw_data[DATA_W-1:1];
                else
                    regs[hw_addr] <= hw_data;
            end
            if (err_set) regs[0][0] <= 1'b1;
            if (usr_wr_en && host_ro(usr_addr)) regs[usr_addr] <= usr_wdata;
        end
    end

    assign rd_data   = regs[rd_addr];
    assign usr_rdata = regs[usr_raddr];
    assign err_flag  = regs[0][0];
endmodule

// File: rtl/usbcmd_fsm.sv
module usbcmd_fsm
    import usbcmd_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx_not_empty,
    input  logic [BYTE_W-1:0] rx_data,
    output logic              rx_rd,
    input  logic              tx_full,
    output logic [BYTE_W-1:0] tx_data,
    output logic              tx_wr,
    input  logic              acq_not_empty,
    input  logic [DATA_W-1:0] acq_data,
    output logic              acq_rd,
    output logic              hw_en,
    output logic [ADDR_W-1:0] hw_addr,
    output logic [DATA_W-1:0] hw_data,
    output logic              err_set,
    output logic [ADDR_W-1:0] rd_addr,
    input  logic [DATA_W-1:0] rd_data
);
    cmd_state_e state_q, state_d;
    logic [BYTE_W-1:0] op_q;
    logic [DATA_W-1:0] word_q;
    logic              is_read;
    logic [ADDR_W-1:0] op_addr;

    assign is_read = op_q[BYTE_W-1];
    assign op_addr = op_q[ADDR_W-1:0];

    // state register and datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            op_q    <= '0;
            word_q  <= '0;
        end else begin
            state_q <= state_d;
            unique case (state_q)
                ST_TAKE_CMD: if (rx_not_empty) op_q <= rx_data;
                ST_GET_LO:   if (rx_not_empty) word_q[BYTE_W-1:0] <= rx_data;
                ST_GET_HI:   if (rx_not_empty) word_q[DATA_W-1:BYTE_W] <= rx_data;
                ST_RD_REG:   word_q <= rd_data;
                ST_ACQ_POP:  if (acq_not_empty) word_q <= acq_data;
                default:     ;
            endcase
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:     if (rx_not_empty) state_d = ST_TAKE_CMD;
                         else if (acq_not_empty) state_d = ST_ACQ_POP;
            ST_TAKE_CMD: state_d = rx_not_empty ? ST_PARSE : ST_IDLE;
            ST_PARSE:    state_d = is_read ? ST_RD_REG : ST_GET_LO;
            ST_GET_LO:   if (rx_not_empty) state_d = ST_GET_HI;
            ST_GET_HI:   if (rx_not_empty) state_d = ST_WR_REG;
            ST_WR_REG:   state_d = ST_IDLE;
            ST_RD_REG:   state_d = ST_SEND_LO;
            ST_ACQ_POP:  state_d = acq_not_empty ? ST_SEND_LO : ST_IDLE;
            ST_SEND_LO:  if (!tx_full) state_d = ST_SEND_HI;
            ST_SEND_HI:  if (!tx_full) state_d = ST_IDLE;
            default:     state_d = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        rx_rd   = 1'b0;
        tx_wr   = 1'b0;
        tx_data = word_q[BYTE_W-1:0];
        acq_rd  = 1'b0;
        hw_en   = 1'b0;
        err_set = 1'b0;
        unique case (state_q)
            ST_TAKE_CMD, ST_GET_LO, ST_GET_HI: rx_rd = rx_not_empty;
            ST_ACQ_POP:  acq_rd = acq_not_empty;
            ST_WR_REG: begin
                hw_en   = !host_ro(op_addr);
                err_set = host_ro(op_addr);
            end
            ST_SEND_LO:  tx_wr = !tx_full;
            ST_SEND_HI: begin
                tx_wr   = !tx_full;
                tx_data = word_q[DATA_W-1:BYTE_W];
            end
            default: ;
        endcase
    end

    assign hw_addr = op_addr;
    assign hw_data = word_q;
    assign rd_addr = op_addr;
endmodule

// File: rtl/usb_cmd_handler.sv
module usb_cmd_handler
    import usbcmd_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx_not_empty,
    input  logic [BYTE_W-1:0] rx_data,
    output logic              rx_rd,
    input  logic              tx_full,
    output logic [BYTE_W-1:0] tx_data,
    output logic              tx_wr,
    input  logic              acq_not_empty,
    input  logic [DATA_W-1:0] acq_data,
    output logic              acq_rd,
    input  logic              usr_wr_en,
    input  logic [ADDR_W-1:0] usr_addr,
    input  logic [DATA_W-1:0] usr_wdata,
    input  logic [ADDR_W-1:0] usr_raddr,
    output logic [DATA_W-1:0] usr_rdata
);
    logic              hw_en, err_set, err_flag;
    logic [ADDR_W-1:0] hw_addr, rd_addr;
    logic [DATA_W-1:0] hw_data, rd_data;

    usbcmd_fsm u_fsm (
        .clk(clk), .rst_n(rst_n),
        .rx_not_empty(rx_not_empty), .rx_data(rx_data), .rx_rd(rx_rd),
        .tx_full(tx_full), .tx_data(tx_data), .tx_wr(tx_wr),
        .acq_not_empty(acq_not_empty), .acq_data(acq_data), .acq_rd(acq_rd),
        .hw_en(hw_en), .hw_addr(hw_addr), .hw_data(hw_data),
        .err_set(err_set), .rd_addr(rd_addr), .rd_data(rd_data)
    );

    usbcmd_reg_bank u_bank (
        .clk(clk), .rst_n(rst_n),
        .hw_en(hw_en), .hw_addr(hw_addr), .hw_data(hw_data),
        .err_set(err_set), .rd_addr(rd_addr), .rd_data(rd_data),
        .usr_wr_en(usr_wr_en), .usr_addr(usr_addr), .usr_wdata(usr_wdata),
        .usr_raddr(usr_raddr), .usr_rdata(usr_rdata), .err_flag(err_flag)
    );
endmodule

// File: rtl/usb_cmd_checker.sv
module usb_cmd_checker (
    input logic clk,
    input logic rst_n,
    input logic rx_not_empty,
    input logic rx_rd,
    input logic tx_full,
    input logic tx_wr,
    input logic acq_not_empty,
    input logic acq_rd,
    input logic err_flag
);
    a_r9_rx_pop_guarded: assert property (@(posedge clk) disable iff (!rst_n)
        rx_rd |-> rx_not_empty);
    a_r9_acq_pop_guarded: assert property (@(posedge clk) disable iff (!rst_n)
        acq_rd |-> acq_not_empty);
    a_r5_tx_respects_full: assert property (@(posedge clk) disable iff (!rst_n)
        tx_wr |-> !tx_full);
    a_r7_single_acq_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        acq_rd |=> !acq_rd);
    a_r4_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        err_flag |=> err_flag);
    a_r7_no_pop_while_sending: assert property (@(posedge clk) disable iff (!rst_n)
        tx_wr |-> !acq_rd);
endmodule

bind usb_cmd_handler usb_cmd_checker u_chk (
    .clk(clk), .rst_n(rst_n),
    .rx_not_empty(rx_not_empty), .rx_rd(rx_rd),
    .tx_full(tx_full), .tx_wr(tx_wr),
    .acq_not_empty(acq_not_empty), .acq_rd(acq_rd),
    .err_flag(err_flag)
);

// File: tb/usb_cmd_handler_bench.sv
`timescale 1ns/1ps
module usb_cmd_handler_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tx_full = 1'b0;
    logic        usr_wr_en = 1'b0;
    logic [6:0]  usr_addr = '0;
    logic [15:0] usr_wdata = '0;
    logic [6:0]  usr_raddr = '0;
    logic [15:0] usr_rdata;
    logic        rx_rd, tx_wr, acq_rd;
    logic [7:0]  tx_data;

    logic [7:0]  rxq [64];
    logic [5:0]  rx_head = '0, rx_tail = '0;
    logic [15:0] acqq [16];
    logic [3:0]  acq_head = '0, acq_tail = '0;
    logic [7:0]  txb [256];
    logic [7:0]  tx_cnt = '0;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;

    wire        rx_not_empty  = (rx_head != rx_tail);
    wire [7:0]  rx_data       = rxq[rx_head];
    wire        acq_not_empty = (acq_head != acq_tail);
    wire [15:0] acq_data      = acqq[acq_head];

    always #10 clk = ~clk;

    usb_cmd_handler u_usb_cmd_handler (
        .clk(clk), .rst_n(rst_n),
        .rx_not_empty(rx_not_empty), .rx_data(rx_data), .rx_rd(rx_rd),
        .tx_full(tx_full), .tx_data(tx_data), .tx_wr(tx_wr),
        .acq_not_empty(acq_not_empty), .acq_data(acq_data), .acq_rd(acq_rd),
        .usr_wr_en(usr_wr_en), .usr_addr(usr_addr), .usr_wdata(usr_wdata),
        .usr_raddr(usr_raddr), .usr_rdata(usr_rdata)
    );

    // bridge and acquisition FIFO models
    always @(posedge clk) begin
        if (rx_rd) rx_head <= rx_head + 6'd1;
        if (acq_rd) acq_head <= acq_head + 4'd1;
        if (tx_wr) begin
            txb[tx_cnt] <= tx_data;
            tx_cnt <= tx_cnt + 8'd1;
        end
    end

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 100000) begin
            fails = fails + 1;
            $display("FAIL watchdog: act=%0d cycles exp<=100000", cycles);
            summary();
        end
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: act=0x%0h exp=0x%0h", req, act, exp);
        end
    endtask

    task automatic push_rx(input logic [7:0] b);
        rxq[rx_tail] = b;
        rx_tail = rx_tail + 6'd1;
    endtask

    task automatic host_write(input logic [6:0] a, input logic [15:0] d);
        @(negedge clk);
        push_rx({1'b0, a});
        push_rx(d[7:0]);
        push_rx(d[15:8]);
        repeat (12) @(negedge clk);
    endtask

    task automatic user_write(input logic [6:0] a, input logic [15:0] d);
        @(negedge clk);
        usr_wr_en = 1'b1; usr_addr = a; usr_wdata = d;
        @(negedge clk);
        usr_wr_en = 1'b0;
    endtask

    task automatic user_read(input logic [6:0] a, output logic [15:0] d);
        usr_raddr = a;
        #1 d = usr_rdata;
    endtask

    task automatic t_reset();
        logic [15:0] v;
        check("R1 rx_rd", {31'b0, rx_rd}, 0);
        check("R1 tx_wr", {31'b0, tx_wr}, 0);
        check("R1 acq_rd", {31'b0, acq_rd}, 0);
        user_read(7'd0, v);   check("R1 reg0", {16'b0, v}, 0);
        user_read(7'd127, v); check("R1 reg127", {16'b0, v}, 0);
    endtask

    task automatic t_write_read();
        logic [15:0] v;
        logic [7:0] base;
        host_write(7'd5, 16'hBEEF);
        user_read(7'd5, v); check("R2 write general", {16'b0, v}, 32'hBEEF);
        host_write(7'd110, 16'h1234);
        user_read(7'd110, v); check("R2 write ch2 out", {16'b0, v}, 32'h1234);
        base = tx_cnt;
        @(negedge clk); push_rx({1'b1, 7'd5});
        repeat (12) @(negedge clk);
        check("R3 reply count", {24'b0, tx_cnt - base}, 2);
        check("R3 reply low", {24'b0, txb[base]}, 32'hEF);
        check("R3 reply high", {24'b0, txb[base + 8'd1]}, 32'hBE);
    endtask

    task automatic t_ro_write();
        logic [15:0] v;
        user_write(7'd30, 16'h5555);
        user_read(7'd30, v); check("R8 user fills ch1 in", {16'b0, v}, 32'h5555);
        host_write(7'd30, 16'hAAAA);
        user_read(7'd30, v); check("R4 dropped write", {16'b0, v}, 32'h5555);
        user_read(7'd0, v);  check("R4 error bit set", {31'b0, v[0]}, 1);
        host_write(7'd7, 16'h0102);
        user_read(7'd7, v);  check("R4 bytes consumed", {16'b0, v}, 32'h0102);
        host_write(7'd0, 16'h0000);
        user_read(7'd0, v);  check("R4 error sticky", {16'b0, v}, 32'h0001);
        host_write(7'd0, 16'hF0F0);
        user_read(7'd0, v);  check("R2 reg0 upper bits", {16'b0, v}, 32'hF0F1);
    endtask

    task automatic t_user_ignored();
        logic [15:0] v;
        user_write(7'd60, 16'h7777);
        user_read(7'd60, v); check("R8 user write ch1 out ignored", {16'b0, v}, 0);
        user_write(7'd3, 16'h7777);
        user_read(7'd3, v);  check("R8 user write general ignored", {16'b0, v}, 0);
    endtask

    task automatic t_stall();
        logic [7:0] base;
        base = tx_cnt;
        @(negedge clk); tx_full = 1'b1; push_rx({1'b1, 7'd7});
        repeat (30) @(negedge clk);
        check("R5 no write while full", {24'b0, tx_cnt - base}, 0);
        tx_full = 1'b0;
        repeat (12) @(negedge clk);
        check("R5 reply after release", {24'b0, tx_cnt - base}, 2);
        check("R5 low byte", {24'b0, txb[base]}, 32'h02);
        check("R5 high byte", {24'b0, txb[base + 8'd1]}, 32'h01);
    endtask

    task automatic t_stream();
        logic [7:0] base;
        base = tx_cnt;
        @(negedge clk);
        acqq[acq_tail] = 16'h1357; acq_tail = acq_tail + 4'd1;
        acqq[acq_tail] = 16'h2468; acq_tail = acq_tail + 4'd1;
        repeat (20) @(negedge clk);
        check("R6 byte count", {24'b0, tx_cnt - base}, 4);
        check("R6 b0", {24'b0, txb[base]}, 32'h57);
        check("R6 b1", {24'b0, txb[base + 8'd1]}, 32'h13);
        check("R6 b2", {24'b0, txb[base + 8'd2]}, 32'h68);
        check("R6 b3", {24'b0, txb[base + 8'd3]}, 32'h24);
        check("R9 acq drained", {28'b0, acq_tail - acq_head}, 0);
    endtask

    task automatic t_priority();
        logic [7:0] base;
        base = tx_cnt;
        @(negedge clk);
        acqq[acq_tail] = 16'hA1B2; acq_tail = acq_tail + 4'd1;
        push_rx({1'b1, 7'd7});
        repeat (30) @(negedge clk);
        check("R7 byte count", {24'b0, tx_cnt - base}, 4);
        check("R7 reply first lo", {24'b0, txb[base]}, 32'h02);
        check("R7 reply first hi", {24'b0, txb[base + 8'd1]}, 32'h01);
        check("R7 sample lo", {24'b0, txb[base + 8'd2]}, 32'hB2);
        check("R7 sample hi", {24'b0, txb[base + 8'd3]}, 32'hA1);
        check("R9 rx drained", {26'b0, rx_tail - rx_head}, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        t_write_read();
        t_ro_write();
        t_user_ignored();
        t_stall();
        t_stream();
        t_priority();
        repeat (5) @(negedge clk);
        summary();
    end
endmodule